// File: doc/BRIEF.md
# Timed Power-Off Supervisor

This block owns the decision of whether the node's voltage regulator is enabled. It lets the node turn itself off completely for a programmed time and then come back up. It runs from an always-on clock that keeps going while the rest of the node is unpowered.

Ownership of the enable pin moves between two parties in a fixed order:

- **Host ownership.** While the host owns the pin, the enable simply follows the host's drive.
- **Shutdown.** The host first loads an off-time, counted in prescaled ticks, through a parallel write port. With the mode switch in its standby position, it then requests shutdown. The supervisor takes the pin, drops the enable and counts down. While it counts, nothing the host or the switch does has any effect.
- **Wake.** When the count runs out, the supervisor raises the enable and flags a wake interrupt. It keeps the enable high until the host claims the pin again.

An off-time of zero is never accepted. A write of zero is refused and raises an error flag. A shutdown request made while the stored off-time is still zero is also refused and raises the same flag. After reset the supervisor holds the enable high and waits for the host's first claim.

Top module: `pwroff_supervisor`

## Requirements
- R1: After reset, `reg_en`=1, `sup_owns`=1, `wake_irq`=0 and `load_err`=0.
- R2: When `host_claim` is high while the supervisor holds the pin awake, `sup_owns` drops at the next edge. While the host owns the pin, `reg_en` equals the `host_en` value sampled at the previous clock edge.
- R3: With `mode_stby`=0 (switch in the ON position), `sleep_req` has no effect: the host keeps ownership, `reg_en` keeps following `host_en`, and `load_err` does not change.
- R4: With `mode_stby`=1, host ownership and a nonzero stored off-time, a `sleep_req` sampled at an edge gives `reg_en`=0 and `sup_owns`=1 after that edge.
- R5: The enable stays low for exactly N×PRESCALE clock cycles, where N is the stored off-time in ticks. `reg_en` returns to 1 at the edge that ends that interval.
- R6: While the node is off, `host_en`, `host_claim`, `mode_stby`, `sleep_req` and `cfg_wr` have no effect. Only the expiry of the count raises `reg_en`, and a write made while off does not change the stored off-time.
- R7: After wake, `reg_en` stays 1 with `sup_owns`=1 for as long as `host_claim` is low. A high `host_claim` returns ownership to the host.
- R8: A write of 0 leaves the stored off-time unchanged and sets `load_err`. A nonzero write stores the value and clears `load_err`. A shutdown request in standby while the stored off-time is 0 is refused (no shutdown) and sets `load_err`.
- R9: `wake_irq` rises at the wake edge and stays high until `irq_clr` is sampled high. If `irq_clr` coincides with the wake edge, the flag is still set.
- R10: The off-time used for a shutdown is the last nonzero value written before the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_stby | input | 1 | Mode switch: 1 = standby (shutdown armed), 0 = ON |
| host_claim | input | 1 | Host claims ownership of the regulator enable |
| host_en | input | 1 | Host drive of the regulator enable |
| sleep_req | input | 1 | Host request to shut the node down |
| cfg_wr | input | 1 | Write strobe for the off-time |
| cfg_data | input | DUR_W | Off-time in ticks |
| irq_clr | input | 1 | Clears the wake interrupt |
| reg_en | output | 1 | Regulator enable (registered) |
| sup_owns | output | 1 | 1 while the supervisor owns the enable |
| wake_irq | output | 1 | Wake interrupt flag |
| load_err | output | 1 | Zero off-time refused |

## Verification
Expiry of the countdown and a host clear of the wake interrupt can land on the same clock edge. The bench provokes this by holding `irq_clr` high during the last cycle of a shutdown. It then judges that the flag comes out set, with `reg_en` high at the exact cycle predicted from N×PRESCALE.

A second collision is a write arriving while the node is off. The bench makes such a write and then runs a later shutdown. It confirms that the later shutdown still lasts for the earlier stored value.

// File: rtl/pws_pkg.sv
package pws_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE_HOLD = 2'd0,   // supervisor holds enable high, waits for host claim
    ST_HOST       = 2'd1,   // host drives the enable
    ST_OFF        = 2'd2    // enable low, countdown running
  } pws_state_e;
endpackage

// File: rtl/pws_tick.sv
module pws_tick #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  generate
    if (PRESCALE == 1) begin : g_direct
      assign tick = run;
    end else begin : g_div
      logic [PW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst || !run) begin
          cnt_q <= '0;
        end else if (cnt_q == PW'(PRESCALE - 1)) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      assign tick = run && (cnt_q == PW'(PRESCALE - 1));
    end
  endgenerate
endmodule

// File: rtl/pws_duration.sv
module pws_duration #(
  parameter int DUR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [DUR_W-1:0] wr_data,
  input  logic             lock,
  input  logic             arm_reject,
  output logic [DUR_W-1:0] dur,
  output logic             dur_valid,
  output logic             load_err
);
  logic [DUR_W-1:0] dur_q;
  logic             err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dur_q <= '0;
      err_q <= 1'b0;
    end else if (wr && !lock) begin
      if (wr_data == '0) begin
        err_q <= 1'b1;
      end else begin
        dur_q <= wr_data;
        err_q <= 1'b0;
      end
    end else if (arm_reject) begin
      err_q <= 1'b1;
    end
  end

  assign dur       = dur_q;
  assign dur_valid = (dur_q != '0);
  assign load_err  = err_q;
endmodule

// File: rtl/pws_countdown.sv
module pws_countdown #(
  parameter int DUR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DUR_W-1:0] load_val,
  input  logic             active,
  input  logic             tick,
  output logic             expire
);
  logic [DUR_W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
    end else if (load) begin
      rem_q <= load_val;
    end else if (active && tick && rem_q != '0) begin
      rem_q <= rem_q - 1'b1;
    end
  end

  assign expire = active && tick && (rem_q == DUR_W'(1));
endmodule

// File: rtl/pws_ctrl.sv
module pws_ctrl
  import pws_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_stby,
  input  logic       host_claim,
  input  logic       host_en,
  input  logic       sleep_req,
  input  logic       irq_clr,
  input  logic       dur_valid,
  input  logic       expire,
  output pws_state_e state,
  output logic       load,
  output logic       arm_reject,
  output logic       reg_en,
  output logic       sup_owns,
  output logic       wake_irq
);
  pws_state_e state_q, state_d;
  logic       en_q, own_q, irq_q;
  logic       arm_try;

  assign arm_try    = (state_q == ST_HOST) && sleep_req && mode_stby;
  assign load       = arm_try && dur_valid;
  assign arm_reject = arm_try && !dur_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_AWAKE_HOLD: if (host_claim) state_d = ST_HOST;
      ST_HOST:       if (load)       state_d = ST_OFF;
      ST_OFF:        if (expire)     state_d = ST_AWAKE_HOLD;
      default:                       state_d = ST_AWAKE_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_AWAKE_HOLD;
      en_q    <= 1'b1;
      own_q   <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      en_q    <= (state_d == ST_HOST) ? host_en : (state_d == ST_AWAKE_HOLD);
      own_q   <= (state_d != ST_HOST);
      if (expire)       irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
    end
  end

  assign state    = state_q;
  assign reg_en   = en_q;
  assign sup_owns = own_q;
  assign wake_irq = irq_q;
endmodule

// File: rtl/pwroff_supervisor.sv
module pwroff_supervisor
  import pws_pkg::*;
#(
  parameter int DUR_W    = 32,
  parameter int PRESCALE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_stby,
  input  logic             host_claim,
  input  logic             host_en,
  input  logic             sleep_req,
  input  logic             cfg_wr,
  input  logic [DUR_W-1:0] cfg_data,
  input  logic             irq_clr,
  output logic             reg_en,
  output logic             sup_owns,
  output logic             wake_irq,
  output logic             load_err
);
  pws_state_e       state;
  logic             load, arm_reject, expire, tick, dur_valid, is_off;
  logic [DUR_W-1:0] dur;

  assign is_off = (state == ST_OFF);

  pws_ctrl u_ctrl (
    .clk(clk), .rst(rst), .mode_stby(mode_stby), .host_claim(host_claim),
    .host_en(host_en), .sleep_req(sleep_req), .irq_clr(irq_clr),
    .dur_valid(dur_valid), .expire(expire), .state(state), .load(load),
    .arm_reject(arm_reject), .reg_en(reg_en), .sup_owns(sup_owns),
    .wake_irq(wake_irq)
  );

  pws_duration #(.DUR_W(DUR_W)) u_dur (
    .clk(clk), .rst(rst), .wr(cfg_wr), .wr_data(cfg_data), .lock(is_off),
    .arm_reject(arm_reject), .dur(dur), .dur_valid(dur_valid),
    .load_err(load_err)
  );

  pws_tick #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst(rst), .run(is_off), .tick(tick)
  );

  pws_countdown #(.DUR_W(DUR_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .load_val(dur), .active(is_off),
    .tick(tick), .expire(expire)
  );
endmodule

// File: rtl/pws_checker.sv
module pws_checker (
  input logic clk,
  input logic rst,
  input logic mode_stby,
  input logic host_claim,
  input logic host_en,
  input logic irq_clr,
  input logic reg_en,
  input logic sup_owns,
  input logic wake_irq
);
  AST_HOST_FOLLOWS_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !sup_owns |=> (sup_owns || reg_en == $past(host_en)));                       // R2
  AST_ON_MODE_KEEPS_HOST: assert property (@(posedge clk) disable iff (rst)
    (!sup_owns && !mode_stby) |=> !sup_owns);                                    // R3
  AST_TAKEOVER_DROPS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(sup_owns) |-> !reg_en);                                                // R4
  AST_OFF_ONLY_TIMER_WAKES: assert property (@(posedge clk) disable iff (rst)
    (sup_owns && !reg_en) |=> (!reg_en || wake_irq));                            // R6
  AST_HOLD_UNTIL_CLAIM: assert property (@(posedge clk) disable iff (rst)
    (sup_owns && reg_en && !host_claim) |=> (sup_owns && reg_en));               // R7
  AST_WAKE_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
    (sup_owns && $rose(reg_en)) |-> wake_irq);                                   // R9
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (wake_irq && !irq_clr) |=> wake_irq);                                        // R9
endmodule

bind pwroff_supervisor pws_checker u_pws_checker (
  .clk(clk), .rst(rst), .mode_stby(mode_stby), .host_claim(host_claim),
  .host_en(host_en), .irq_clr(irq_clr), .reg_en(reg_en),
  .sup_owns(sup_owns), .wake_irq(wake_irq)
);

// File: tb/pwroff_supervisor_tb.sv
`timescale 1ns/1ps
module pwroff_supervisor_tb;
  localparam int DW = 32;
  localparam int P  = 4;

  logic clk = 1'b0;
  logic rst, mode_stby, host_claim, host_en, sleep_req, cfg_wr, irq_clr;
  logic [DW-1:0] cfg_data;
  logic reg_en, sup_owns, wake_irq, load_err;
  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwroff_supervisor #(.DUR_W(DW), .PRESCALE(P)) u_dut (
    .clk(clk), .rst(rst), .mode_stby(mode_stby), .host_claim(host_claim),
    .host_en(host_en), .sleep_req(sleep_req), .cfg_wr(cfg_wr),
    .cfg_data(cfg_data), .irq_clr(irq_clr), .reg_en(reg_en),
    .sup_owns(sup_owns), .wake_irq(wake_irq), .load_err(load_err)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic write_dur(int unsigned v);
    cfg_wr = 1'b1; cfg_data = v; step(); cfg_wr = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; mode_stby = 1'b0; host_claim = 1'b0; host_en = 1'b0;
    sleep_req = 1'b0; cfg_wr = 1'b0; cfg_data = '0; irq_clr = 1'b0;
    repeat (3) step();
    rst = 1'b0; step();
    check("R1 reg_en", reg_en, 1'b1);
    check("R1 sup_owns", sup_owns, 1'b1);
    check("R1 wake_irq", wake_irq, 1'b0);
    check("R1 load_err", load_err, 1'b0);
  endtask

  task automatic t_claim();
    host_claim = 1'b1; host_en = 1'b1; step();
    check("R2 owner", sup_owns, 1'b0);
    check("R2 en", reg_en, 1'b1);
    host_en = 1'b0; step();
    check("R2 follow low", reg_en, 1'b0);
    host_en = 1'b1; step();
    check("R2 follow high", reg_en, 1'b1);
  endtask

  task automatic t_zero_arm();
    mode_stby = 1'b1; sleep_req = 1'b1; step(); sleep_req = 1'b0;
    check("R8 no shutdown", sup_owns, 1'b0);
    check("R8 en kept", reg_en, 1'b1);
    check("R8 err on arm", load_err, 1'b1);
    write_dur(3);
    check("R8 err cleared", load_err, 1'b0);
  endtask

  task automatic t_on_mode();
    bit bad = 1'b0;
    mode_stby = 1'b0; sleep_req = 1'b1;
    for (int i = 0; i < 4; i++) begin
      host_en = i[0]; step();
      if (sup_owns !== 1'b0 || reg_en !== i[0]) bad = 1'b1;
    end
    sleep_req = 1'b0; host_en = 1'b1; step();
    check("R3 request ignored", bad, 1'b0);
    check("R3 err unchanged", load_err, 1'b0);
    write_dur(0);
    check("R8 zero write err", load_err, 1'b1);
  endtask

  task automatic t_sleep(int n, bit clr_at_wake, string tag);
    bit bad = 1'b0;
    mode_stby = 1'b1; sleep_req = 1'b1; step(); sleep_req = 1'b0;
    check({tag, " R4 en low"}, reg_en, 1'b0);
    check({tag, " R4 owner"}, sup_owns, 1'b1);
    for (int i = 1; i < n * P; i++) begin
      host_en = 1'b1; host_claim = 1'b1; mode_stby = i[0]; sleep_req = 1'b1;
      cfg_wr = 1'b1; cfg_data = 1; irq_clr = 1'b1;
      step();
      if (reg_en !== 1'b0) bad = 1'b1;
    end
    check({tag, " R6 off held"}, bad, 1'b0);
    host_claim = 1'b0; host_en = 1'b0; mode_stby = 1'b1; sleep_req = 1'b0;
    cfg_wr = 1'b0; irq_clr = clr_at_wake;
    step(); irq_clr = 1'b0;
    check({tag, " R5 en at N*P"}, reg_en, 1'b1);
    check({tag, " R7 owner"}, sup_owns, 1'b1);
    check({tag, " R9 irq"}, wake_irq, 1'b1);
    repeat (3) step();
    check({tag, " R7 hold en"}, reg_en, 1'b1);
    check({tag, " R9 irq sticky"}, wake_irq, 1'b1);
    irq_clr = 1'b1; step(); irq_clr = 1'b0;
    check({tag, " R9 irq clr"}, wake_irq, 1'b0);
    host_claim = 1'b1; host_en = 1'b1; step();
    check({tag, " R7 handback"}, sup_owns, 1'b0);
  endtask

  initial begin
    t_reset();
    t_claim();
    t_zero_arm();
    t_on_mode();
    t_sleep(3, 1'b0, "R10 first");
    t_sleep(3, 1'b1, "R6 write-while-off");
    write_dur(2);
    t_sleep(2, 1'b0, "R10 reload");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule